// File: doc/BRIEF.md
# Four-Register File with Parallel Shift Step

This block holds four 16-bit general-purpose registers for a small datapath. Three operand buses, called A, B and I, read the registers in parallel. Each bus has its own 2-bit select. A write-back multiplexer picks one of four result sources. In the normal mode that value is written into one register, chosen by an address, when the write enable is high.

For iterative multiply and divide, the controller raises a step-mode input. In that mode each register has its own one-bit left shifter. Every register whose shift-enable bit is set moves one place left and takes its own serial-in bit at bit 0. This can happen in all four registers in the same cycle. The sequencing of the multiply or divide belongs to the controller, not to this block.

Top module: `quad_regfile`

## Requirements
- R1: While `rst` is high at a rising clock edge, all four registers are cleared to 0x0000, and they read as zero afterwards.
- R2: Buses A, B and I each show, combinationally, the register named by their own 2-bit select (0 to 3 = R0 to R3). The three buses are independent, and each bus shows the value held before the next clock edge.
- R3: `wb_bus` shows the source chosen by `wb_sel`: 0 = `src_alu`, 1 = `src_add`, 2 = `src_load`, 3 = `src_aux`.
- R4: With `step_mode` low and `wr_en` high, the register at `wr_addr` loads `wb_bus` at the clock edge. No other register changes, so at most one register is written per cycle.
- R5: With `step_mode` low and `wr_en` low, no register changes.
- R6: With `step_mode` high, each register k with `shift_en[k]` set becomes its old value shifted left by one with `shift_in[k]` at bit 0. Any number of registers may do this in the same cycle. Registers with `shift_en[k]` clear hold their value, and so does their serial-in bit.
- R7: With `step_mode` high, `wr_en`, `wr_addr` and `wb_bus` have no effect on any register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_sel_a | input | 2 | Register select for bus A |
| rd_sel_b | input | 2 | Register select for bus B |
| rd_sel_i | input | 2 | Register select for bus I |
| wb_sel | input | 2 | Write-back source select |
| src_alu | input | 16 | Write-back source 0 |
| src_add | input | 16 | Write-back source 1 |
| src_load | input | 16 | Write-back source 2 |
| src_aux | input | 16 | Write-back source 3 |
| wr_en | input | 1 | Normal-mode write enable |
| wr_addr | input | 2 | Normal-mode destination register |
| step_mode | input | 1 | Parallel shift-step mode |
| shift_en | input | 4 | Per-register shift enable, bit k for register k |
| shift_in | input | 4 | Per-register serial-in bit, bit k for register k |
| bus_a | output | 16 | Operand bus A |
| bus_b | output | 16 | Operand bus B |
| bus_i | output | 16 | Operand bus I |
| wb_bus | output | 16 | Selected write-back value |

## Verification
The assertions check every register on every cycle for three outcomes: the shift result in step mode, the loaded value in a normal write, and the held value otherwise. The same checks cover the rule that step mode overrides a write. A further assertion confirms that no more than one register updates per cycle outside step mode.

Only the bench scenarios can show the following:
- that the read buses are independent of each other;
- that a read shows the old value before the edge and the new value after it;
- that the write-back source mapping is correct;
- that a chain of writes and shift steps ends with the register contents the requirements predict.

// File: rtl/rf_pkg.sv
package rf_pkg;

  // Per-lane update decision for one clock edge
  typedef enum logic [1:0] {
    LANE_HOLD  = 2'd0,
    LANE_LOAD  = 2'd1,
    LANE_SHIFT = 2'd2
  } lane_op_e;

  // Names of the write-back sources by select value
  typedef enum logic [1:0] {
    WB_ALU  = 2'd0,
    WB_ADD  = 2'd1,
    WB_LOAD = 2'd2,
    WB_AUX  = 2'd3
  } wb_src_e;

endpackage

// File: rtl/rf_wb_mux.sv
module rf_wb_mux #(
  parameter int DW   = 16,
  parameter int NSRC = 4,
  parameter int SW   = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic [NSRC*DW-1:0] srcs,
  input  logic [SW-1:0]      sel,
  output logic [DW-1:0]      dout
);

  always_comb begin
    dout = '0;
    for (int s = 0; s < NSRC; s++) begin
      if (sel == SW'(s)) dout = srcs[s*DW +: DW];
    end
  end

endmodule

// File: rtl/rf_read_port.sv
module rf_read_port #(
  parameter int DW   = 16,
  parameter int NREG = 4,
  parameter int AW   = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic [NREG*DW-1:0] regs,
  input  logic [AW-1:0]      sel,
  output logic [DW-1:0]      dout
);

  always_comb begin
    dout = '0;
    for (int r = 0; r < NREG; r++) begin
      if (sel == AW'(r)) dout = regs[r*DW +: DW];
    end
  end

endmodule

// File: rtl/rf_lane.sv
module rf_lane
  import rf_pkg::*;
#(
  parameter int DW  = 16,
  parameter int AW  = 2,
  parameter int IDX = 0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          step,
  input  logic          shift_en,
  input  logic          shift_in,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wb_bus,
  output logic [DW-1:0] q,
  output logic          upd
);

  lane_op_e op;
  logic     addr_hit;

  assign addr_hit = (wr_addr == AW'(IDX));

  // Step mode wins over a normal write
  always_comb begin
    if (step) op = shift_en ? LANE_SHIFT : LANE_HOLD;
    else      op = (wr_en && addr_hit) ? LANE_LOAD : LANE_HOLD;
  end

  assign upd = (op != LANE_HOLD);

  always_ff @(posedge clk) begin
    if (rst) begin
      q <= '0;
    end else begin
      unique case (op)
        LANE_SHIFT: q <= {q[DW-2:0], shift_in};
        LANE_LOAD:  q <= wb_bus;
        default:    q <= q;
      endcase
    end
  end

  // R1
  reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (q == '0));

  // R6
  step_shift_chk: assert property (@(posedge clk) disable iff (rst)
    (step && shift_en) |=> (q == {$past(q[DW-2:0]), $past(shift_in)}));

  // R4
  normal_load_chk: assert property (@(posedge clk) disable iff (rst)
    (!step && wr_en && (wr_addr == AW'(IDX))) |=> (q == $past(wb_bus)));

  // R5 R7
  lane_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!(step && shift_en) && !(!step && wr_en && (wr_addr == AW'(IDX))))
      |=> $stable(q));

endmodule

// File: rtl/quad_regfile.sv
module quad_regfile #(
  parameter int DW   = 16,
  parameter int NREG = 4,
  parameter int NSRC = 4,
  parameter int AW   = (NREG > 1) ? $clog2(NREG) : 1,
  parameter int SW   = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [AW-1:0]   rd_sel_a,
  input  logic [AW-1:0]   rd_sel_b,
  input  logic [AW-1:0]   rd_sel_i,
  input  logic [SW-1:0]   wb_sel,
  input  logic [DW-1:0]   src_alu,
  input  logic [DW-1:0]   src_add,
  input  logic [DW-1:0]   src_load,
  input  logic [DW-1:0]   src_aux,
  input  logic            wr_en,
  input  logic [AW-1:0]   wr_addr,
  input  logic            step_mode,
  input  logic [NREG-1:0] shift_en,
  input  logic [NREG-1:0] shift_in,
  output logic [DW-1:0]   bus_a,
  output logic [DW-1:0]   bus_b,
  output logic [DW-1:0]   bus_i,
  output logic [DW-1:0]   wb_bus
);

  localparam int NPORT = 3;

  logic [NSRC*DW-1:0]           src_flat;
  logic [NREG*DW-1:0]           reg_flat;
  logic [NREG-1:0]              lane_upd;
  logic [NPORT-1:0][AW-1:0]     port_sel;
  logic [NPORT-1:0][DW-1:0]     port_bus;

  assign src_flat = {src_aux, src_load, src_add, src_alu};

  rf_wb_mux #(.DW(DW), .NSRC(NSRC), .SW(SW)) u_wb_mux (
    .srcs (src_flat),
    .sel  (wb_sel),
    .dout (wb_bus)
  );

  for (genvar k = 0; k < NREG; k++) begin : g_lane
    rf_lane #(.DW(DW), .AW(AW), .IDX(k)) u_lane (
      .clk      (clk),
      .rst      (rst),
      .step     (step_mode),
      .shift_en (shift_en[k]),
      .shift_in (shift_in[k]),
      .wr_en    (wr_en),
      .wr_addr  (wr_addr),
      .wb_bus   (wb_bus),
      .q        (reg_flat[k*DW +: DW]),
      .upd      (lane_upd[k])
    );
  end

  assign port_sel = {rd_sel_i, rd_sel_b, rd_sel_a};

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    rf_read_port #(.DW(DW), .NREG(NREG), .AW(AW)) u_port (
      .regs (reg_flat),
      .sel  (port_sel[p]),
      .dout (port_bus[p])
    );
  end

  assign bus_a = port_bus[0];
  assign bus_b = port_bus[1];
  assign bus_i = port_bus[2];

  // R4
  single_write_chk: assert property (@(posedge clk) disable iff (rst)
    !step_mode |-> $onehot0(lane_upd));

  // R6
  step_enable_only_chk: assert property (@(posedge clk) disable iff (rst)
    step_mode |-> ((lane_upd & ~shift_en) == '0));

endmodule

// File: tb/quad_regfile_bench.sv
module quad_regfile_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  rd_sel_a = '0, rd_sel_b = '0, rd_sel_i = '0;
  logic [1:0]  wb_sel = '0;
  logic [15:0] src_alu  = 16'hA5A5;
  logic [15:0] src_add  = 16'h1234;
  logic [15:0] src_load = 16'h8001;
  logic [15:0] src_aux  = 16'h00FF;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic        step_mode = 1'b0;
  logic [3:0]  shift_en = '0, shift_in = '0;
  logic [15:0] bus_a, bus_b, bus_i, wb_bus;

  int n_cmp = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  quad_regfile u_quad_regfile (
    .clk(clk), .rst(rst),
    .rd_sel_a(rd_sel_a), .rd_sel_b(rd_sel_b), .rd_sel_i(rd_sel_i),
    .wb_sel(wb_sel),
    .src_alu(src_alu), .src_add(src_add), .src_load(src_load), .src_aux(src_aux),
    .wr_en(wr_en), .wr_addr(wr_addr), .step_mode(step_mode),
    .shift_en(shift_en), .shift_in(shift_in),
    .bus_a(bus_a), .bus_b(bus_b), .bus_i(bus_i), .wb_bus(wb_bus)
  );

  typedef struct packed {
    logic        step;
    logic        we;
    logic [1:0]  wa;
    logic [1:0]  src;
    logic [3:0]  en;
    logic [3:0]  sin;
    logic [15:0] e0, e1, e2, e3;
  } vec_t;

  localparam int NVEC = 10;
  localparam vec_t VECS [NVEC] = '{
    '{1'b0, 1'b1, 2'd0, 2'd0, 4'h0, 4'h0, 16'hA5A5, 16'h0000, 16'h0000, 16'h0000}, // R4
    '{1'b0, 1'b1, 2'd1, 2'd1, 4'h0, 4'h0, 16'hA5A5, 16'h1234, 16'h0000, 16'h0000}, // R4
    '{1'b0, 1'b1, 2'd2, 2'd2, 4'h0, 4'h0, 16'hA5A5, 16'h1234, 16'h8001, 16'h0000}, // R4
    '{1'b0, 1'b1, 2'd3, 2'd3, 4'h0, 4'h0, 16'hA5A5, 16'h1234, 16'h8001, 16'h00FF}, // R4
    '{1'b0, 1'b0, 2'd0, 2'd1, 4'h0, 4'h0, 16'hA5A5, 16'h1234, 16'h8001, 16'h00FF}, // R5
    '{1'b1, 1'b0, 2'd0, 2'd0, 4'hF, 4'hA, 16'h4B4A, 16'h2469, 16'h0002, 16'h01FF}, // R6
    '{1'b1, 1'b1, 2'd1, 2'd0, 4'h5, 4'hF, 16'h9695, 16'h2469, 16'h0005, 16'h01FF}, // R6 R7
    '{1'b1, 1'b1, 2'd3, 2'd0, 4'h0, 4'hF, 16'h9695, 16'h2469, 16'h0005, 16'h01FF}, // R7
    '{1'b0, 1'b1, 2'd3, 2'd1, 4'h0, 4'h0, 16'h9695, 16'h2469, 16'h0005, 16'h1234}, // R4
    '{1'b1, 1'b0, 2'd0, 2'd0, 4'h8, 4'h8, 16'h9695, 16'h2469, 16'h0005, 16'h2469}  // R6
  };

  task automatic cmp(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Reads all four registers through the buses, using different selects
  task automatic check_regs(input string req, input logic [15:0] e0, e1, e2, e3);
    rd_sel_a = 2'd0; rd_sel_b = 2'd1; rd_sel_i = 2'd2;
    #1;
    cmp(req, bus_a, e0);
    cmp(req, bus_b, e1);
    cmp(req, bus_i, e2);
    rd_sel_a = 2'd3; rd_sel_b = 2'd2; rd_sel_i = 2'd0;
    #1;
    cmp(req, bus_a, e3);
    cmp(req, bus_b, e2);
    cmp(req, bus_i, e0);
  endtask

  initial begin : watchdog
    #100000;
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin : main
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    check_regs("R1 reset", 16'h0, 16'h0, 16'h0, 16'h0);

    // R3: write-back source mapping
    for (int s = 0; s < 4; s++) begin
      wb_sel = 2'(s);
      #1;
      case (s)
        0: cmp("R3 sel0", wb_bus, 16'hA5A5);
        1: cmp("R3 sel1", wb_bus, 16'h1234);
        2: cmp("R3 sel2", wb_bus, 16'h8001);
        default: cmp("R3 sel3", wb_bus, 16'h00FF);
      endcase
    end

    // Vector table
    for (int v = 0; v < NVEC; v++) begin
      @(negedge clk);
      step_mode = VECS[v].step;
      wr_en     = VECS[v].we;
      wr_addr   = VECS[v].wa;
      wb_sel    = VECS[v].src;
      shift_en  = VECS[v].en;
      shift_in  = VECS[v].sin;
      @(posedge clk);
      #2;
      check_regs($sformatf("R4-7 vec%0d", v), VECS[v].e0, VECS[v].e1, VECS[v].e2, VECS[v].e3);
    end

    // R2: read shows old value until the edge, new value after it
    @(negedge clk);
    step_mode = 1'b0; shift_en = '0; shift_in = '0;
    wr_en = 1'b1; wr_addr = 2'd0; wb_sel = 2'd3;
    rd_sel_a = 2'd0;
    #1;
    cmp("R2 before edge", bus_a, 16'h9695);
    @(posedge clk);
    #2;
    rd_sel_a = 2'd0;
    #1;
    cmp("R2 after edge", bus_a, 16'h00FF);

    // R1: reset in the middle of a run
    @(negedge clk);
    wr_en = 1'b0;
    rst = 1'b1;
    @(posedge clk);
    #2;
    rst = 1'b0;
    check_regs("R1 mid-run", 16'h0, 16'h0, 16'h0, 16'h0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule